// File: doc/BRIEF.md
# Timer Ring Overrun Monitor

This block watches a set of timer rings and records each ring that misses its service deadline. For every ring it keeps one outstanding-request flag. The flag is raised when the ring's interval expires and dropped when the scheduler reports that the ring's bucket traversal is done. If the interval expires again while the flag is still up and no service arrives in that cycle, the ring has been overrun. Its bit in a sticky error vector is then set.

Software clears error bits by writing to the error register. Each 1 in the write data clears the matching bit, and each 0 leaves its bit alone. A second register, the enable mask, selects which error bits may raise the interrupt. The single interrupt output is registered. A read strobe returns either register one cycle later. The expiry and service pulses come from the timer scheduler, one bit per ring.

Top module: `ring_overrun_mon`

## Requirements
- R1: While reset is asserted and right after it, the outputs `pending_o`, `err_o`, `irq_o` and `rd_data_o` are all zero, and the enable mask is zero.
- R2: For each ring, an expiry pulse sets the outstanding flag on the next clock. A service pulse clears it. If both pulses arrive in the same cycle, the flag is set after that clock.
- R3: An expiry pulse for a ring whose outstanding flag is already set, with no service pulse for that ring in the same cycle, sets that ring's error bit on the next clock.
- R4: An expiry on a ring whose flag is clear sets no error bit. An expiry that coincides with a service pulse on that ring also sets no error bit.
- R5: Error bits are sticky. Expiry pulses, service pulses and mask writes never clear them.
- R6: A write with `wr_sel_i`=0 updates the error vector on the next clock to old AND NOT `wr_data_i`.
- R7: If an overrun on a ring and a clear of that ring's bit fall in the same cycle, the bit is set after the clock.
- R8: A write with `wr_sel_i`=1 loads `wr_data_i` into the enable mask. Bit i of the mask enables the interrupt for ring i.
- R9: `irq_o` in cycle n+1 equals the OR over all rings of (error bit AND mask bit) in cycle n.
- R10: A read strobe with `rd_sel_i`=0 returns the error vector, and with `rd_sel_i`=1 returns the mask. The value appears on `rd_data_o` after the next clock and reflects the contents before any write in the same cycle. Without a strobe, `rd_data_o` holds its value.
- R11: The rings are independent. Pulses on one ring never change the flag or the error bit of another ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expire_i | input | NR | Per-ring interval-expiry pulse |
| serviced_i | input | NR | Per-ring traversal-done pulse from the scheduler |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 error vector (clear mask), 1 enable mask |
| wr_data_i | input | NR | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | Read target: 0 error vector, 1 enable mask |
| rd_data_o | output | NR | Registered read data |
| pending_o | output | NR | Per-ring outstanding-request flags |
| err_o | output | NR | Sticky per-ring overrun vector |
| irq_o | output | 1 | Registered interrupt |

## Verification
Two kinds of event can meet in one cycle. First, a ring's second expiry, which sets its error bit, can coincide with a software clear of that same bit. Second, an expiry can coincide with the service pulse that retires the previous request. The directed phase sets up each collision on purpose. It first builds an outstanding request, then fires the expiry with the clear write, and separately fires the expiry with the service pulse. A long pseudo-random phase makes both collisions occur often across all rings. The behavioural reference model decides each outcome from the rules: a set beats a clear, and a service in the same cycle prevents the overrun. Every output is compared against the model on every clock.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int unsigned RINGS_DEF = 16;

  typedef enum logic {
    SEL_ERR  = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ovr_ring_track.sv
// One ring: outstanding-request flag and overrun detection.
module ovr_ring_track (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic serviced_i,
  output logic pending_o,
  output logic overrun_o
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    // A same-cycle service retires the old request; the expiry opens a new one.
    overrun_o = expire_i & pend_q & ~serviced_i;
    pend_en   = expire_i | serviced_i;
    pend_d    = expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/ovr_err_bank.sv
// Sticky error vector, interrupt enable mask and read port.
module ovr_err_bank
  import ovr_pkg::*;
#(
  parameter int unsigned NR = RINGS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] overrun_i,
  input  logic          wr_en_i,
  input  reg_sel_e      wr_sel_i,
  input  logic [NR-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  reg_sel_e      rd_sel_i,
  output logic [NR-1:0] err_o,
  output logic [NR-1:0] mask_o,
  output logic [NR-1:0] rd_data_o
);
  logic [NR-1:0] err_q,  err_d;
  logic [NR-1:0] mask_q, mask_d;
  logic [NR-1:0] rd_q,   rd_d;
  logic [NR-1:0] clr_vec;
  logic          err_en, mask_en;

  always_comb begin
    clr_vec = (wr_en_i && wr_sel_i == SEL_ERR) ? wr_data_i : '0;
    err_en  = (|clr_vec) | (|overrun_i);
    // Set wins over a clear of the same bit.
    err_d   = (err_q & ~clr_vec) | overrun_i;
    mask_en = wr_en_i && wr_sel_i == SEL_MASK;
    mask_d  = wr_data_i;
    rd_d    = (rd_sel_i == SEL_MASK) ? mask_q : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign err_o     = err_q;
  assign mask_o    = mask_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/ovr_irq_gen.sv
// Registered interrupt from the masked error vector.
module ovr_irq_gen #(
  parameter int unsigned NR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] err_i,
  input  logic [NR-1:0] mask_i,
  output logic          irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(err_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ring_overrun_mon.sv
module ring_overrun_mon
  import ovr_pkg::*;
#(
  parameter int unsigned NR = RINGS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] expire_i,
  input  logic [NR-1:0] serviced_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [NR-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          rd_sel_i,
  output logic [NR-1:0] rd_data_o,
  output logic [NR-1:0] pending_o,
  output logic [NR-1:0] err_o,
  output logic          irq_o
);
  logic [NR-1:0] overrun;
  logic [NR-1:0] mask_q;

  for (genvar g = 0; g < NR; g++) begin : g_ring
    ovr_ring_track u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire_i   (expire_i[g]),
      .serviced_i (serviced_i[g]),
      .pending_o  (pending_o[g]),
      .overrun_o  (overrun[g])
    );
  end

  ovr_err_bank #(.NR(NR)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .overrun_i (overrun),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (reg_sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (reg_sel_e'(rd_sel_i)),
    .err_o     (err_o),
    .mask_o    (mask_q),
    .rd_data_o (rd_data_o)
  );

  ovr_irq_gen #(.NR(NR)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_i  (err_o),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ring_overrun_mon_chk.sv
module ring_overrun_mon_chk #(
  parameter int unsigned NR = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NR-1:0] expire_i,
  input logic [NR-1:0] serviced_i,
  input logic          wr_en_i,
  input logic          wr_sel_i,
  input logic [NR-1:0] wr_data_i,
  input logic [NR-1:0] pending_o,
  input logic [NR-1:0] err_o,
  input logic [NR-1:0] mask_q,
  input logic          irq_o
);
  logic [NR-1:0] evt;
  logic [NR-1:0] clr;
  assign evt = expire_i & pending_o & ~serviced_i;
  assign clr = (wr_en_i && !wr_sel_i) ? wr_data_i : '0;

  // R2: every expiring ring shows its flag after the clock
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire_i) |=> ((pending_o & $past(expire_i)) == $past(expire_i)));

  // R3 / R7: overrun sets the bit even against a clear
  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((err_o & $past(evt)) == $past(evt)));

  // R4: no error bit rises without an overrun
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_o & ~$past(err_o) & ~$past(evt)) == '0));

  // R5 / R6: a bit falls only when written with a 1
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err_o) & ~$past(clr) & ~err_o) == '0));

  // R9: interrupt follows masked errors one cycle later
  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(err_o) & $past(mask_q))));
endmodule

bind ring_overrun_mon ring_overrun_mon_chk #(.NR(NR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .expire_i   (expire_i),
  .serviced_i (serviced_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .pending_o  (pending_o),
  .err_o      (err_o),
  .mask_q     (mask_q),
  .irq_o      (irq_o)
);

// File: tb/tb_ring_overrun_mon.sv
`timescale 1ns/1ps
module tb_ring_overrun_mon;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NR-1:0] expire_i, serviced_i, wr_data_i;
  logic          wr_en_i, wr_sel_i, rd_en_i, rd_sel_i;
  logic [NR-1:0] rd_data_o, pending_o, err_o;
  logic          irq_o;

  always #5 clk = ~clk;

  ring_overrun_mon #(.NR(NR)) dut (.*);

  // reference model state
  logic [NR-1:0] m_pend, m_err, m_mask, m_rd;
  logic          m_irq;
  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2/R11 pending", pending_o, m_pend);
    chk("R3/R5/R6/R7 err", err_o, m_err);
    chk("R9 irq", {{(NR-1){1'b0}}, irq_o}, {{(NR-1){1'b0}}, m_irq});
    chk("R10 rd_data", rd_data_o, m_rd);
  endtask

  // one clock: compare, drive, predict, advance
  task automatic step(input logic [NR-1:0] ex, input logic [NR-1:0] sv,
                      input logic we, input logic ws, input logic [NR-1:0] wd,
                      input logic re, input logic rs);
    logic [NR-1:0] n_pend, n_err, n_mask, n_rd;
    logic          n_irq;
    compare_all();
    expire_i = ex; serviced_i = sv; wr_en_i = we; wr_sel_i = ws;
    wr_data_i = wd; rd_en_i = re; rd_sel_i = rs;
    n_err = m_err;
    for (int i = 0; i < NR; i++) begin
      bit over;
      over = ex[i] && m_pend[i] && !sv[i];
      if (we && !ws && wd[i]) n_err[i] = 1'b0;
      if (over) n_err[i] = 1'b1;
      if (ex[i]) n_pend[i] = 1'b1;
      else if (sv[i]) n_pend[i] = 1'b0;
      else n_pend[i] = m_pend[i];
    end
    n_mask = (we && ws) ? wd : m_mask;
    n_irq  = (m_err & m_mask) != 0;
    n_rd   = re ? (rs ? m_mask : m_err) : m_rd;
    @(posedge clk);
    m_pend = n_pend; m_err = n_err; m_mask = n_mask; m_irq = n_irq; m_rd = n_rd;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, '0, 0, 0, '0, 0, 0);
  endtask

  logic [31:0] lfsr;

  initial begin
    rst_n = 1'b0;
    expire_i = '0; serviced_i = '0; wr_en_i = 0; wr_sel_i = 0;
    wr_data_i = '0; rd_en_i = 0; rd_sel_i = 0;
    m_pend = '0; m_err = '0; m_mask = '0; m_rd = '0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pending", pending_o, '0);
    chk("R1 err", err_o, '0);
    chk("R1 rd", rd_data_o, '0);
    chk("R1 irq", {15'd0, irq_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: mask reads zero after reset
    step('0, '0, 0, 0, '0, 1, 1);
    chk("R1 mask", rd_data_o, '0);

    // R2: expiry then service, single ring
    step(16'h0001, '0, 0, 0, '0, 0, 0);
    step('0, 16'h0001, 0, 0, '0, 0, 0);
    // R4: expiry on clear flag gives no error
    step(16'h0002, '0, 0, 0, '0, 0, 0);
    // R2/R4: expiry with service while pending -> flag stays, no error
    step(16'h0002, 16'h0002, 0, 0, '0, 0, 0);
    // R3: second expiry without service -> error
    step(16'h0002, '0, 0, 0, '0, 0, 0);
    idle(2);
    chk("R3 err bit1", err_o, 16'h0002);
    // R5: service and expiry do not clear
    step('0, 16'h0002, 0, 0, '0, 0, 0);
    step(16'h0002, '0, 0, 1, 16'h0000, 0, 0);
    idle(1);
    chk("R5 sticky", err_o, 16'h0002);
    // R8/R9: enable mask, interrupt one cycle after
    step('0, '0, 1, 1, 16'h0002, 0, 0);
    idle(2);
    chk("R9 irq high", {15'd0, irq_o}, 16'h0001);
    // R10: read both registers; read sees pre-write mask
    step('0, '0, 1, 1, 16'h00F0, 1, 1);
    chk("R10 read mask old", rd_data_o, 16'h0002);
    step('0, '0, 0, 0, '0, 1, 0);
    chk("R10 read err", rd_data_o, 16'h0002);
    // R6: clear with data mask leaves other bits
    step(16'h0100, '0, 0, 0, '0, 0, 0);
    step(16'h0100, '0, 0, 0, '0, 0, 0);
    step('0, '0, 1, 0, 16'h0002, 0, 0);
    chk("R6 clear bit1", err_o, 16'h0100);
    // R7: overrun collides with clear of same bit
    step(16'h0100, '0, 1, 0, 16'h0100, 0, 0);
    chk("R7 set wins", err_o, 16'h0100);
    step('0, '0, 1, 0, 16'hFFFF, 0, 0);
    chk("R6 clear all", err_o, '0);
    step('0, 16'hFFFF, 0, 0, '0, 0, 0);

    // R11 and collisions: pseudo-random traffic, all rings
    lfsr = 32'hACE1_2357;
    for (int k = 0; k < 3000; k++) begin
      logic [NR-1:0] ex, sv, wd;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ex = lfsr[15:0] & lfsr[31:16] & {lfsr[7:0], lfsr[15:8]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sv = lfsr[15:0] & lfsr[31:16];
      wd = lfsr[23:8];
      step(ex, sv, lfsr[2] & lfsr[5], lfsr[9], wd, lfsr[3], lfsr[11]);
    end
    idle(2);
    compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule